// File: doc/BRIEF.md
# Serial System Bus Master

This block moves a byte-wide parallel system bus with a 16-bit address over two serial lanes. Each system-clock period is cut into 16 bit slots. The first 8 slots carry the address: lane A sends the upper address byte and lane B sends the lower byte at the same time. Lane B then carries the data byte in slots 8 to 15. A 2-bit mode output tells every listener what the lanes hold during each half.

A host hands in one request at a time on a parallel port: address, write data, direction and a valid strobe. A write uses one system cycle. A read uses two. The first read cycle carries the address and then idles. In the second cycle, the addressed target drives the byte back on a return line during the last 8 slots. Because of this split, targets only need to keep pace with the system rate. The block samples that byte in the middle of each slot. It raises a one-clock done pulse at the start of the following system cycle, with the read byte on the response bus.

The block runs on a fast clock that has `OVS` ticks per bit slot. From this clock it derives the slot timing and the system-clock phase that listeners use.

Top module: `serbus_master`

## Requirements
- R1: While reset is asserted, bus_mode is 11 (idle), lane_a and lane_b are 1, rsp_done is 0 and req_ready is 0.
- R2: In the first half (slots 0 to 7) of a write or of the first read cycle, bus_mode is 00 (address). Lane A carries req_addr[15:8] and lane B carries req_addr[7:0], both MSB first, one bit per slot.
- R3: In the second half (slots 8 to 15) of a write cycle, bus_mode is 10 (write data). Lane B carries req_wdata MSB first and lane A is held at 1.
- R4: rsp_done is high for exactly one clock, in the first clock of the system cycle that follows the end of a transfer. For a write, that is one system cycle after acceptance. For a read, it is two.
- R5: In the second half of the first read cycle, bus_mode is 11 (idle) and both lanes are 1.
- R6: In the first half of the second read cycle, bus_mode is 11 and both lanes are 1. In the second half, bus_mode is 01 (read data) and both lanes stay at 1.
- R7: The read byte is taken MSB first from lane_rx. Each bit is sampled on the clock tick at index OVS/2 within its slot of the read-data window. The assembled byte is shown on rsp_rdata while rsp_done is high.
- R8: req_ready is high only in the last clock of a system cycle, and only when no read is waiting for its second cycle. Requests are accepted only then, and the transfer starts at slot 0 of the next cycle. Back-to-back transfers leave no gap.
- R9: bus_mode changes only at an 8-slot half boundary.
- R10: sys_clk_o is 1 during slots 0 to 7 and 0 during slots 8 to 15. Its rising edge marks where written data becomes valid to listeners.
- R11: With no request pending, the bus stays idle: bus_mode 11 and both lanes 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, OVS ticks per bit slot |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req_valid | input | 1 | Host request strobe, held until accepted |
| req_ready | output | 1 | High in the clock where a request may be accepted |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 16 | Transfer address |
| req_wdata | input | 8 | Write data |
| rsp_done | output | 1 | One-clock pulse when a transfer ends |
| rsp_rdata | output | 8 | Read byte, valid with rsp_done after a read |
| bus_mode | output | 2 | Lane content: 00 address, 01 read data, 10 write data, 11 idle |
| lane_a | output | 1 | Serial lane for the upper address byte |
| lane_b | output | 1 | Serial lane for the lower address byte, then the write data |
| lane_rx | input | 1 | Read byte returned by the target |
| sys_clk_o | output | 1 | Derived system-clock phase |

## Verification
The assertions assume three things about the host:
- it holds req_valid steady until req_ready is seen;
- the target drives lane_rx settled at the mid-slot sampling tick;
- rst_n is released away from the clock edge.

The stimulus drives every input on the falling clock edge and keeps each request asserted until the acceptance edge. Outside the sampling tick it drives the inverse bit on lane_rx, so a sample taken at the wrong tick shows up as a wrong byte. The checks cover writes, reads, back-to-back mixed transfers and idle gaps.

// File: rtl/sbm_pkg.sv
package sbm_pkg;
  typedef enum logic [1:0] {
    MODE_ADDR  = 2'b00,
    MODE_RDATA = 2'b01,
    MODE_WDATA = 2'b10,
    MODE_IDLE  = 2'b11
  } mode_e;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_WRITE,
    PH_READ_REQ,
    PH_READ_RSP
  } phase_e;
endpackage

// File: rtl/sbm_slot_timer.sv
module sbm_slot_timer #(
  parameter int DATA_W = 8,
  parameter int OVS    = 4,
  localparam int SLOTS = 2 * DATA_W,
  localparam int TOTAL = SLOTS * OVS,
  localparam int CNT_W = $clog2(TOTAL),
  localparam int BIT_W = $clog2(DATA_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] cnt_o,
  output logic [BIT_W-1:0] bit_o,
  output logic             half_o,
  output logic             mid_o,
  output logic             last_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  int slot_i, sub_i;

  // slot position decode
  always_comb begin
    slot_i = int'(cnt_q) / OVS;
    sub_i  = int'(cnt_q) % OVS;
    half_o = (slot_i >= DATA_W);
    bit_o  = BIT_W'(slot_i % DATA_W);
    mid_o  = (sub_i == OVS / 2);
    last_o = (int'(cnt_q) == TOTAL - 1);
  end

  always_comb begin
    if (last_o) cnt_d = '0;
    else        cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/sbm_lane_mux.sv
module sbm_lane_mux
  import sbm_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int ADDR_W = 2 * DATA_W,
  localparam int BIT_W  = $clog2(DATA_W)
) (
  input  phase_e            phase_i,
  input  logic              half_i,
  input  logic [BIT_W-1:0]  bit_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output mode_e             mode_o,
  output logic              lane_a_o,
  output logic              lane_b_o
);
  logic [BIT_W-1:0] pick;

  // MSB first: slot 0 carries the top bit
  assign pick = BIT_W'(DATA_W - 1) - bit_i;

  always_comb begin
    mode_o   = MODE_IDLE;
    lane_a_o = 1'b1;
    lane_b_o = 1'b1;
    case (phase_i)
      PH_WRITE: begin
        if (!half_i) begin
          mode_o   = MODE_ADDR;
          lane_a_o = addr_i[DATA_W + int'(pick)];
          lane_b_o = addr_i[int'(pick)];
        end else begin
          mode_o   = MODE_WDATA;
          lane_b_o = wdata_i[pick];
        end
      end
      PH_READ_REQ: begin
        if (!half_i) begin
          mode_o   = MODE_ADDR;
          lane_a_o = addr_i[DATA_W + int'(pick)];
          lane_b_o = addr_i[int'(pick)];
        end
      end
      PH_READ_RSP: begin
        if (half_i) mode_o = MODE_RDATA;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/sbm_read_sampler.sv
module sbm_read_sampler #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_en,
  input  logic              lane_rx,
  output logic [DATA_W-1:0] byte_o
);
  logic [DATA_W-1:0] sh_q, sh_d;

  always_comb begin
    sh_d = sh_q;
    if (sample_en) sh_d = {sh_q[DATA_W-2:0], lane_rx};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign byte_o = sh_q;
endmodule

// File: rtl/serbus_master.sv
module serbus_master
  import sbm_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 4,
  localparam int ADDR_W = 2 * DATA_W,
  localparam int TOTAL  = 2 * DATA_W * OVS,
  localparam int CNT_W  = $clog2(TOTAL),
  localparam int BIT_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [1:0]        bus_mode,
  output logic              lane_a,
  output logic              lane_b,
  input  logic              lane_rx,
  output logic              sys_clk_o
);
  logic [CNT_W-1:0]  tick_cnt;
  logic [BIT_W-1:0]  bit_idx;
  logic              half, mid, last;
  phase_e            phase_q, phase_d;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              done_q, done_d, accept, sample_en;
  mode_e             mode;

  sbm_slot_timer #(.DATA_W(DATA_W), .OVS(OVS)) u_timer (
    .clk(clk), .rst_n(rst_n), .cnt_o(tick_cnt), .bit_o(bit_idx),
    .half_o(half), .mid_o(mid), .last_o(last)
  );

  // a read waiting for its answer cycle blocks new requests
  assign req_ready = last && (phase_q != PH_READ_REQ);
  assign accept    = req_valid && req_ready;

  // next-state logic
  always_comb begin
    phase_d = phase_q;
    done_d  = 1'b0;
    if (last) begin
      case (phase_q)
        PH_WRITE:    begin phase_d = PH_IDLE;     done_d = 1'b1; end
        PH_READ_REQ: phase_d = PH_READ_RSP;
        PH_READ_RSP: begin phase_d = PH_IDLE;     done_d = 1'b1; end
        default:     phase_d = PH_IDLE;
      endcase
      if (accept) phase_d = req_write ? PH_WRITE : PH_READ_REQ;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      done_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  sbm_lane_mux #(.DATA_W(DATA_W)) u_mux (
    .phase_i(phase_q), .half_i(half), .bit_i(bit_idx),
    .addr_i(addr_q), .wdata_i(wdata_q),
    .mode_o(mode), .lane_a_o(lane_a), .lane_b_o(lane_b)
  );

  assign sample_en = (phase_q == PH_READ_RSP) && half && mid;

  sbm_read_sampler #(.DATA_W(DATA_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .sample_en(sample_en),
    .lane_rx(lane_rx), .byte_o(rsp_rdata)
  );

  assign bus_mode  = mode;
  assign rsp_done  = done_q;
  assign sys_clk_o = ~half;
endmodule

// File: rtl/sbm_checker.sv
module sbm_checker #(
  parameter int DATA_W = 8,
  parameter int OVS    = 4,
  localparam int HALF_T = DATA_W * OVS,
  localparam int TOTAL  = 2 * HALF_T,
  localparam int CNT_W  = $clog2(TOTAL)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_ready,
  input logic             rsp_done,
  input logic [1:0]       bus_mode,
  input logic             lane_a,
  input logic             lane_b,
  input logic             sys_clk_o,
  input logic [CNT_W-1:0] tick_cnt
);
  always_comb begin
    if (!rst_n) begin
      AST_RESET_IDLE: assert (bus_mode == 2'b11 && lane_a && lane_b && !rsp_done && !req_ready); // R1
    end
  end

  AST_WDATA_LANE_A_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    bus_mode == 2'b10 |-> lane_a); // R3

  AST_DONE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> int'(tick_cnt) == 0); // R4

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done); // R4

  AST_RDATA_LANES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    bus_mode == 2'b01 |-> (lane_a && lane_b)); // R6

  AST_READY_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> int'(tick_cnt) == TOTAL - 1); // R8

  AST_MODE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_mode != $past(bus_mode) |-> (int'(tick_cnt) % HALF_T) == 0); // R9

  AST_SYSCLK_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_clk_o) |-> int'(tick_cnt) == 0); // R10
endmodule

bind serbus_master sbm_checker #(.DATA_W(DATA_W), .OVS(OVS)) i_sbm_checker (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_done(rsp_done),
  .bus_mode(bus_mode), .lane_a(lane_a), .lane_b(lane_b),
  .sys_clk_o(sys_clk_o), .tick_cnt(tick_cnt)
);

// File: tb/test_serbus_master.sv
`timescale 1ns/1ps
module test_serbus_master;
  localparam int CYC = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, lane_rx = 1'b1;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, rsp_done, lane_a, lane_b, sys_clk_o;
  logic [7:0]  rsp_rdata;
  logic [1:0]  bus_mode;

  int checks = 0, errors = 0;
  int t = 0;
  bit finished = 0;

  typedef struct { bit wr; logic [7:0] data; } item_t;
  item_t sb_q[$];

  serbus_master i_serbus_master (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .bus_mode(bus_mode),
    .lane_a(lane_a), .lane_b(lane_b), .lane_rx(lane_rx), .sys_clk_o(sys_clk_o)
  );

  always #2 clk = ~clk;

  always @(posedge clk) if (rst_n) t <= t + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h (t=%0d)", req, act, exp, t);
    end
  endtask

  // expected {mode, lane_a, lane_b}: ph 0 idle, 1 write, 2 read req, 3 read rsp
  function automatic logic [3:0] exp_bus(int ph, int c, logic [15:0] a, logic [7:0] w);
    int b;
    bit h;
    h = (c >= 32);
    b = 7 - ((c / 4) % 8);
    case (ph)
      1: exp_bus = h ? {2'b10, 1'b1, w[b]} : {2'b00, a[8+b], a[b]};
      2: exp_bus = h ? 4'b1111 : {2'b00, a[8+b], a[b]};
      3: exp_bus = h ? 4'b0111 : 4'b1111;
      default: exp_bus = 4'b1111;
    endcase
  endfunction

  function automatic string req_of(int ph, int c);
    if (ph == 0) return "R11";
    if (c < 32) return (ph == 3) ? "R6" : "R2";
    if (ph == 1) return "R3";
    if (ph == 2) return "R5";
    return "R6";
  endfunction

  // monitor: pops expected responses as done pulses appear
  always @(negedge clk) begin
    if (rst_n && rsp_done) begin
      chk((t % CYC) == 0, "R4", t % CYC, 0);
      if (sb_q.size() == 0) chk(1'b0, "R4", 1, 0);
      else begin
        item_t it;
        it = sb_q.pop_front();
        if (!it.wr) chk(rsp_rdata == it.data, "R7", rsp_rdata, it.data);
      end
    end
  end

  // driver: call at a falling edge
  task automatic xfer(input bit wr, input logic [15:0] a, input logic [7:0] w, input logic [7:0] rb);
    item_t it;
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = w;
    while (!req_ready) @(negedge clk);
    chk((t % CYC) == CYC - 1, "R8", t % CYC, CYC - 1);
    @(posedge clk);
    #0.5 req_valid = 1'b0;
    it.wr = wr; it.data = rb;
    sb_q.push_back(it);
    for (int cy = 0; cy < (wr ? 1 : 2); cy++) begin
      int ph;
      ph = wr ? 1 : (cy == 0 ? 2 : 3);
      for (int c = 0; c < CYC; c++) begin
        logic [3:0] e;
        @(negedge clk);
        e = exp_bus(ph, c, a, w);
        chk({bus_mode, lane_a, lane_b} == e, req_of(ph, c), {bus_mode, lane_a, lane_b}, e);
        chk(sys_clk_o == (c < 32), "R10", sys_clk_o, c < 32);
        if (c != CYC - 1 || ph == 2) chk(req_ready == 1'b0, "R8", req_ready, 0);
        if (ph == 3 && c >= 32) begin
          int bp;
          bp = 7 - (c - 32) / 4;
          lane_rx = ((c % 4) == 2) ? rb[bp] : ~rb[bp];
        end else lane_rx = 1'b1;
      end
    end
  endtask

  task automatic idle_cycles(input int n);
    for (int i = 0; i < n * CYC; i++) begin
      @(negedge clk);
      chk({bus_mode, lane_a, lane_b} == 4'b1111, "R11", {bus_mode, lane_a, lane_b}, 4'hf);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk({bus_mode, lane_a, lane_b} == 4'b1111, "R1", {bus_mode, lane_a, lane_b}, 4'hf);
    chk(rsp_done == 1'b0, "R1", rsp_done, 0);
    chk(req_ready == 1'b0, "R1", req_ready, 0);
    rst_n = 1'b1;
    idle_cycles(1);
    xfer(1'b1, 16'hA53C, 8'h96, 8'h00);
    xfer(1'b0, 16'h1E87, 8'h00, 8'hC3);
    xfer(1'b0, 16'hFFFF, 8'h00, 8'h5A);
    xfer(1'b1, 16'h0000, 8'hFF, 8'h00);
    idle_cycles(1);
    xfer(1'b0, 16'h8001, 8'h00, 8'h01);
    xfer(1'b1, 16'h7FFE, 8'h00, 8'h00);
    xfer(1'b0, 16'h4C2D, 8'h00, 8'h80);
    idle_cycles(2);
    chk(sb_q.size() == 0, "R4", sb_q.size(), 0);
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule